// File: doc/BRIEF.md
# Parallel Link Pattern Tester

This block exercises a wide parallel link that carries one word per bunch crossing between two trigger processors. Its transmit side drives a test sequence onto the link: a walking one, a walking zero, or a short sample sequence that software preloads. The first word of every sequence carries a start-of-sequence marker on a separate line.

The receive side first repairs two common faults: lines whose polarity is reversed and lines that arrive in the wrong positions. It does this with a per-bit inversion mask and a per-bit source-select map. Once armed, it waits for the marker. From the marked word on, it compares every valid word with the sequence it expects. It then records the number of failing words and which lines failed, and keeps the first words after the marker in a capture FIFO for readback. If no marker arrives within a fixed number of cycles, it reports that lock failed.

Top module: `link_tester`

## Requirements
- R1: After `tx_run` rises, the next cycle shows the first word with `tx_valid` and `tx_marker` both high. `tx_marker` stays low on every later word of that run. While `tx_run` is low, `tx_valid` is low.
- R2: Mode 0 (walking one): word n of a run has exactly one bit set, at position n mod W. It advances one bit per word and wraps after bit W-1.
- R3: Mode 1 (walking zero): word n is the bitwise complement of the mode 0 word n.
- R4: Mode 2 (replay): word n equals sample entry n mod SD. Entries are written through `smp_we`/`smp_addr`/`smp_wdata`.
- R5: Received bit i after repair equals received line `cfg_perm[i*PIW +: PIW]` XOR `cfg_inv[i]`. A link that inverts and permutes lines, with the matching configuration applied, produces no errors.
- R6: After `rx_arm`, words that arrive before the first valid word with `rx_marker` high are neither compared nor captured. The marked word itself is compared against sequence word 0. `locked` rises and stays high until the next arm.
- R7: If no marked valid word arrives within LOCK_TIMEOUT cycles after the arm cycle, `no_lock` goes high exactly then, and not before.
- R8: While locked, each valid word that differs from the expected word increments `err_count` by one (saturating). `err_bits` accumulates the OR of all differing bit positions.
- R9: The FIFO captures repaired words in order, starting with the marked word. It keeps the first FIFO_DEPTH words, drops later words while full, and shows the oldest word on `fifo_dout`. `fifo_rd` pops it.
- R10: `rx_arm` clears `err_count`, `err_bits`, `locked`, `no_lock` and the FIFO, and latches `cfg_mode` for the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | Pattern: 0 walking one, 1 walking zero, 2 replay, 3 as 0 |
| cfg_inv | input | W | Per-bit polarity correction mask |
| cfg_perm | input | W*PIW | Per-bit source line select |
| smp_we | input | 1 | Sample entry write strobe |
| smp_addr | input | SAW | Sample entry index |
| smp_wdata | input | W | Sample entry value |
| tx_run | input | 1 | Transmit enable; rising starts a sequence |
| tx_data | output | W | Transmitted word |
| tx_marker | output | 1 | Start-of-sequence marker |
| tx_valid | output | 1 | Transmitted word valid |
| rx_data | input | W | Received raw word |
| rx_marker | input | 1 | Received marker line |
| rx_valid | input | 1 | Received word valid |
| rx_arm | input | 1 | Arm the checker and clear results |
| locked | output | 1 | Marker found, comparing |
| no_lock | output | 1 | Marker timeout expired |
| err_count | output | CNT_W | Mismatched word count |
| err_bits | output | W | Sticky failed-line mask |
| fifo_rd | input | 1 | Pop capture FIFO |
| fifo_dout | output | W | Oldest captured word |
| fifo_empty | output | 1 | Capture FIFO empty |
| fifo_full | output | 1 | Capture FIFO full |

## Verification
If the expected-sequence index slips, every compared word after the slip fails. `err_count` then climbs by one per crossing, starting two cycles after the faulty word enters. A wrong repair map shows the same symptom, and `err_bits` names the lines involved. A corrupted timeout counter or lock state shows up at `no_lock`, either before or after LOCK_TIMEOUT cycles. A faulty FIFO pointer shows up on readback as words out of order or words missing.

// File: rtl/lt_pkg.sv
package lt_pkg;
    typedef enum logic [1:0] {
        PAT_WALK1  = 2'd0,
        PAT_WALK0  = 2'd1,
        PAT_SAMPLE = 2'd2,
        PAT_RSVD   = 2'd3
    } pat_mode_e;

    typedef enum logic [1:0] {
        CHK_IDLE   = 2'd0,
        CHK_SEEK   = 2'd1,
        CHK_LOCK   = 2'd2,
        CHK_NOLOCK = 2'd3
    } chk_state_e;
endpackage

// File: rtl/lt_pat_word.sv
module lt_pat_word
    import lt_pkg::*;
#(
    parameter int W   = 26,
    parameter int SD  = 8,
    parameter int IXW = 5
) (
    input  pat_mode_e        mode,
    input  logic [IXW-1:0]   idx,
    input  logic [W-1:0]     smp_word,
    output logic [W-1:0]     word,
    output logic [IXW-1:0]   idx_next
);
    logic [W-1:0]   onehot;
    logic [IXW-1:0] last;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            onehot[i] = (idx == IXW'(i));
        end
        case (mode)
            PAT_WALK0:  word = ~onehot;
            PAT_SAMPLE: word = smp_word;
            default:    word = onehot;
        endcase
        last     = (mode == PAT_SAMPLE) ? IXW'(SD - 1) : IXW'(W - 1);
        idx_next = (idx >= last) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/lt_tx.sv
module lt_tx
    import lt_pkg::*;
#(
    parameter int W   = 26,
    parameter int SD  = 8,
    parameter int IXW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  pat_mode_e      cfg_mode,
    input  logic [W-1:0]   smp_word,
    output logic [IXW-1:0] rd_idx,
    output logic [W-1:0]   tx_data,
    output logic           tx_marker,
    output logic           tx_valid
);
    typedef struct packed {
        logic           active;
        pat_mode_e      mode;
        logic [IXW-1:0] nidx;
        logic [W-1:0]   data;
        logic           marker;
        logic           valid;
    } tx_st_t;

    tx_st_t         st_d, st_q;
    pat_mode_e      g_mode;
    logic [IXW-1:0] g_idx, g_next;
    logic [W-1:0]   g_word;

    assign g_mode = st_q.active ? st_q.mode : cfg_mode;
    assign g_idx  = st_q.active ? st_q.nidx : '0;
    assign rd_idx = g_idx;

    lt_pat_word #(.W(W), .SD(SD), .IXW(IXW)) i_gen (
        .mode(g_mode), .idx(g_idx), .smp_word(smp_word),
        .word(g_word), .idx_next(g_next)
    );

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.active = 1'b0;
            st_d.valid  = 1'b0;
            st_d.marker = 1'b0;
        end else begin
            st_d.active = 1'b1;
            st_d.mode   = g_mode;
            st_d.nidx   = g_next;
            st_d.data   = g_word;
            st_d.marker = !st_q.active;
            st_d.valid  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_data   = st_q.data;
    assign tx_marker = st_q.marker;
    assign tx_valid  = st_q.valid;

    assert_marker_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.marker |=> !st_q.marker);
    assert_walk1_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && st_q.mode == PAT_WALK1) |-> ($countones(st_q.data) == 1));
endmodule

// File: rtl/lt_fix.sv
module lt_fix #(
    parameter int W   = 26,
    parameter int PIW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     cfg_inv,
    input  logic [W*PIW-1:0] cfg_perm,
    input  logic [W-1:0]     raw_data,
    input  logic             raw_marker,
    input  logic             raw_valid,
    output logic [W-1:0]     fix_data,
    output logic             fix_marker,
    output logic             fix_valid
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         marker;
        logic         valid;
    } fix_st_t;

    fix_st_t      st_d, st_q;
    logic [W-1:0] repaired;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [PIW-1:0] sel;
        assign sel = cfg_perm[i*PIW +: PIW];
        assign repaired[i] = ({1'b0, sel} < (PIW+1)'(W)) ? (raw_data[sel] ^ cfg_inv[i]) : cfg_inv[i];
    end

    always_comb begin
        st_d.data   = repaired;
        st_d.marker = raw_marker;
        st_d.valid  = raw_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fix_data   = st_q.data;
    assign fix_marker = st_q.marker;
    assign fix_valid  = st_q.valid;
endmodule

// File: rtl/lt_chk.sv
module lt_chk
    import lt_pkg::*;
#(
    parameter int W            = 26,
    parameter int SD           = 8,
    parameter int IXW          = 5,
    parameter int LOCK_TIMEOUT = 64,
    parameter int CNT_W        = 32,
    parameter int TW           = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  pat_mode_e        cfg_mode,
    input  logic [W-1:0]     in_data,
    input  logic             in_marker,
    input  logic             in_valid,
    input  logic [W-1:0]     smp_word,
    output logic [IXW-1:0]   rd_idx,
    output logic             locked,
    output logic             no_lock,
    output logic [CNT_W-1:0] err_count,
    output logic [W-1:0]     err_bits,
    output logic             cap_wr
);
    typedef struct packed {
        chk_state_e       st;
        logic [TW-1:0]    tmo;
        logic [IXW-1:0]   idx;
        pat_mode_e        mode;
        logic [CNT_W-1:0] err;
        logic [W-1:0]     sticky;
    } chk_st_t;

    chk_st_t        st_d, st_q;
    logic [W-1:0]   exp_word, miss;
    logic [IXW-1:0] exp_next;
    logic           take;

    assign rd_idx = st_q.idx;

    lt_pat_word #(.W(W), .SD(SD), .IXW(IXW)) i_exp (
        .mode(st_q.mode), .idx(st_q.idx), .smp_word(smp_word),
        .word(exp_word), .idx_next(exp_next)
    );

    assign miss = in_data ^ exp_word;

    always_comb begin
        st_d   = st_q;
        take   = 1'b0;
        cap_wr = 1'b0;
        case (st_q.st)
            CHK_SEEK: begin
                if (in_valid && in_marker) begin
                    st_d.st = CHK_LOCK;
                    take    = 1'b1;
                end else if (st_q.tmo == TW'(LOCK_TIMEOUT - 1)) begin
                    st_d.st = CHK_NOLOCK;
                end else begin
                    st_d.tmo = st_q.tmo + 1'b1;
                end
            end
            CHK_LOCK: take = in_valid;
            default: ;
        endcase
        if (take) begin
            cap_wr   = 1'b1;
            st_d.idx = exp_next;
            if (|miss) begin
                if (st_q.err != '1) st_d.err = st_q.err + 1'b1;
                st_d.sticky = st_q.sticky | miss;
            end
        end
        if (arm) begin
            st_d.st     = CHK_SEEK;
            st_d.tmo    = '0;
            st_d.idx    = '0;
            st_d.err    = '0;
            st_d.sticky = '0;
            st_d.mode   = cfg_mode;
            cap_wr      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked    = (st_q.st == CHK_LOCK);
    assign no_lock   = (st_q.st == CHK_NOLOCK);
    assign err_count = st_q.err;
    assign err_bits  = st_q.sticky;

    assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == CHK_LOCK && !arm) |=> (st_q.st == CHK_LOCK));
    assert_seek_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == CHK_SEEK) |-> (st_q.tmo < TW'(LOCK_TIMEOUT)));
    assert_err_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (st_q.err >= $past(st_q.err)));
    assert_clear_on_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (st_q.err == '0 && st_q.sticky == '0));
endmodule

// File: rtl/lt_fifo.sv
module lt_fifo #(
    parameter int W     = 26,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [PW:0]   cnt;
    } ff_st_t;

    ff_st_t       st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic         do_wr, do_rd;

    assign full  = (st_q.cnt == (PW+1)'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign do_wr = wr && !full && !flush;
    assign do_rd = rd && !empty && !flush;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_wr) st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            if (do_rd) st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            st_d.cnt = st_q.cnt + (PW+1)'(do_wr) - (PW+1)'(do_rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[st_q.wp] <= wdata;
    end

    assign rdata = mem[st_q.rp];

    assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= (PW+1)'(DEPTH));
    assert_fifo_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd && !flush) |=> full);
endmodule

// File: rtl/link_tester.sv
module link_tester
    import lt_pkg::*;
#(
    parameter int W            = 26,
    parameter int SD           = 8,
    parameter int FIFO_DEPTH   = 16,
    parameter int LOCK_TIMEOUT = 64,
    parameter int CNT_W        = 32,
    localparam int PIW         = $clog2(W),
    localparam int SAW         = $clog2(SD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic [W-1:0]     cfg_inv,
    input  logic [W*PIW-1:0] cfg_perm,
    input  logic             smp_we,
    input  logic [SAW-1:0]   smp_addr,
    input  logic [W-1:0]     smp_wdata,
    input  logic             tx_run,
    output logic [W-1:0]     tx_data,
    output logic             tx_marker,
    output logic             tx_valid,
    input  logic [W-1:0]     rx_data,
    input  logic             rx_marker,
    input  logic             rx_valid,
    input  logic             rx_arm,
    output logic             locked,
    output logic             no_lock,
    output logic [CNT_W-1:0] err_count,
    output logic [W-1:0]     err_bits,
    input  logic             fifo_rd,
    output logic [W-1:0]     fifo_dout,
    output logic             fifo_empty,
    output logic             fifo_full
);
    localparam int MAXN = (W > SD) ? W : SD;
    localparam int IXW  = $clog2(MAXN);
    localparam int TW   = $clog2(LOCK_TIMEOUT + 1);
    localparam logic [IXW-1:0] SD_I = IXW'(SD);

    pat_mode_e      mode_in;
    logic [W-1:0]   smp_mem [SD];
    logic [IXW-1:0] tx_idx, chk_idx;
    logic [W-1:0]   tx_smp, chk_smp;
    logic [W-1:0]   fix_data;
    logic           fix_marker, fix_valid, cap_wr;

    assign mode_in = pat_mode_e'(cfg_mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SD; i++) smp_mem[i] <= '0;
        end else if (smp_we) begin
            smp_mem[smp_addr] <= smp_wdata;
        end
    end

    assign tx_smp  = smp_mem[SAW'(tx_idx % SD_I)];
    assign chk_smp = smp_mem[SAW'(chk_idx % SD_I)];

    lt_tx #(.W(W), .SD(SD), .IXW(IXW)) i_tx (
        .clk(clk), .rst_n(rst_n), .run(tx_run), .cfg_mode(mode_in),
        .smp_word(tx_smp), .rd_idx(tx_idx),
        .tx_data(tx_data), .tx_marker(tx_marker), .tx_valid(tx_valid)
    );

    lt_fix #(.W(W), .PIW(PIW)) i_fix (
        .clk(clk), .rst_n(rst_n), .cfg_inv(cfg_inv), .cfg_perm(cfg_perm),
        .raw_data(rx_data), .raw_marker(rx_marker), .raw_valid(rx_valid),
        .fix_data(fix_data), .fix_marker(fix_marker), .fix_valid(fix_valid)
    );

    lt_chk #(.W(W), .SD(SD), .IXW(IXW), .LOCK_TIMEOUT(LOCK_TIMEOUT),
             .CNT_W(CNT_W), .TW(TW)) i_chk (
        .clk(clk), .rst_n(rst_n), .arm(rx_arm), .cfg_mode(mode_in),
        .in_data(fix_data), .in_marker(fix_marker), .in_valid(fix_valid),
        .smp_word(chk_smp), .rd_idx(chk_idx),
        .locked(locked), .no_lock(no_lock), .err_count(err_count),
        .err_bits(err_bits), .cap_wr(cap_wr)
    );

    lt_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_arm), .wr(cap_wr), .wdata(fix_data),
        .rd(fifo_rd), .rdata(fifo_dout), .empty(fifo_empty), .full(fifo_full)
    );
endmodule

// File: tb/test_link_tester.sv
module test_link_tester;
    localparam int W    = 26;
    localparam int SD   = 8;
    localparam int FD   = 16;
    localparam int TMO  = 64;
    localparam int PIW  = $clog2(W);
    localparam int SAW  = $clog2(SD);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_mode = '0;
    logic [W-1:0] cfg_inv = '0;
    logic [W*PIW-1:0] cfg_perm = '0;
    logic smp_we = 1'b0;
    logic [SAW-1:0] smp_addr = '0;
    logic [W-1:0] smp_wdata = '0;
    logic tx_run = 1'b0;
    logic [W-1:0] tx_data;
    logic tx_marker, tx_valid;
    logic [W-1:0] rx_data;
    logic rx_marker, rx_valid;
    logic rx_arm = 1'b0;
    logic locked, no_lock;
    logic [31:0] err_count;
    logic [W-1:0] err_bits;
    logic fifo_rd = 1'b0;
    logic [W-1:0] fifo_dout;
    logic fifo_empty, fifo_full;

    int checks = 0;
    int errors = 0;
    int perm [W];
    logic [W-1:0] inj = '0;
    logic [W-1:0] smp [SD];

    always #2 clk = ~clk;

    link_tester i_link_tester (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_inv(cfg_inv),
        .cfg_perm(cfg_perm), .smp_we(smp_we), .smp_addr(smp_addr),
        .smp_wdata(smp_wdata), .tx_run(tx_run), .tx_data(tx_data),
        .tx_marker(tx_marker), .tx_valid(tx_valid), .rx_data(rx_data),
        .rx_marker(rx_marker), .rx_valid(rx_valid), .rx_arm(rx_arm),
        .locked(locked), .no_lock(no_lock), .err_count(err_count),
        .err_bits(err_bits), .fifo_rd(fifo_rd), .fifo_dout(fifo_dout),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full)
    );

    // Link model: line perm[i] carries word bit i, inverted where cfg_inv is set.
    always_comb begin
        rx_data = '0;
        for (int i = 0; i < W; i++) rx_data[perm[i]] = tx_data[i] ^ cfg_inv[i] ^ inj[i];
    end
    assign rx_marker = tx_marker;
    assign rx_valid  = tx_valid;

    function automatic logic [W-1:0] exp_word(int mode, int n);
        logic [W-1:0] one;
        one = '0;
        one[n % W] = 1'b1;
        case (mode)
            1:       return ~one;
            2:       return smp[n % SD];
            default: return one;
        endcase
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic new_channel();
        for (int i = 0; i < W; i++) perm[i] = i;
        for (int i = W - 1; i > 0; i--) begin
            int j, t;
            j = $urandom_range(i, 0);
            t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
        cfg_inv = W'($urandom);
        for (int i = 0; i < W; i++) cfg_perm[i*PIW +: PIW] = PIW'(perm[i]);
    endtask

    task automatic arm_rx();
        @(negedge clk) rx_arm = 1'b1;
        @(negedge clk) rx_arm = 1'b0;
    endtask

    task automatic run_words(int mode, int nw, int t1, logic [W-1:0] m1, int t2, logic [W-1:0] m2);
        cfg_mode = 2'(mode);
        arm_rx();
        tx_run = 1'b1;
        for (int n = 0; n < nw; n++) begin
            @(negedge clk);
            chk(tx_valid == 1'b1, "R1 valid", 64'(tx_valid), 64'd1);
            chk(tx_marker == (n == 0), "R1 marker", 64'(tx_marker), 64'(n == 0));
            if (mode == 0)      chk(tx_data == exp_word(0, n), "R2 walk1", 64'(tx_data), 64'(exp_word(0, n)));
            else if (mode == 1) chk(tx_data == exp_word(1, n), "R3 walk0", 64'(tx_data), 64'(exp_word(1, n)));
            else                chk(tx_data == exp_word(2, n), "R4 replay", 64'(tx_data), 64'(exp_word(2, n)));
            inj = (n == t1) ? m1 : ((n == t2) ? m2 : '0);
        end
        @(negedge clk);
        tx_run = 1'b0;
        inj = '0;
        repeat (5) @(negedge clk);
        chk(tx_valid == 1'b0, "R1 idle", 64'(tx_valid), 64'd0);
    endtask

    task automatic read_fifo(int mode, int t1, logic [W-1:0] m1);
        chk(fifo_full == 1'b1, "R9 full", 64'(fifo_full), 64'd1);
        for (int k = 0; k < FD; k++) begin
            logic [W-1:0] e;
            e = exp_word(mode, k) ^ ((k == t1) ? m1 : '0);
            chk(fifo_dout == e, "R9 capture", 64'(fifo_dout), 64'(e));
            fifo_rd = 1'b1;
            @(negedge clk);
            fifo_rd = 1'b0;
        end
        chk(fifo_empty == 1'b1, "R9 drained", 64'(fifo_empty), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] m1, m2;
        void'($urandom(32'd4242));
        for (int i = 0; i < W; i++) perm[i] = i;
        for (int i = 0; i < W; i++) cfg_perm[i*PIW +: PIW] = PIW'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_valid == 1'b0, "R1 reset valid", 64'(tx_valid), 64'd0);
        chk(locked == 1'b0, "R6 reset lock", 64'(locked), 64'd0);
        chk(no_lock == 1'b0, "R7 reset", 64'(no_lock), 64'd0);
        chk(err_count == 0, "R8 reset", 64'(err_count), 64'd0);
        chk(fifo_empty == 1'b1, "R9 reset", 64'(fifo_empty), 64'd1);

        // R7 timeout boundary with no traffic
        @(negedge clk) rx_arm = 1'b1;
        @(negedge clk) rx_arm = 1'b0;
        repeat (TMO - 3) @(negedge clk);
        chk(no_lock == 1'b0, "R7 before timeout", 64'(no_lock), 64'd0);
        repeat (5) @(negedge clk);
        chk(no_lock == 1'b1, "R7 after timeout", 64'(no_lock), 64'd1);

        // R2 R5: walking one over a scrambled, inverted link
        new_channel();
        run_words(0, 40, -1, '0, -1, '0);
        chk(locked == 1'b1, "R6 locked", 64'(locked), 64'd1);
        chk(no_lock == 1'b0, "R7 clear when locked", 64'(no_lock), 64'd0);
        chk(err_count == 0, "R5 clean count", 64'(err_count), 64'd0);
        chk(err_bits == '0, "R5 clean bits", 64'(err_bits), 64'd0);
        read_fifo(0, -1, '0);

        // R3 R8: walking zero with two corrupted words
        new_channel();
        m1 = W'($urandom) | W'(1);
        m2 = W'(1) << $urandom_range(W - 1, 0);
        run_words(1, 45, 20, m1, 33, m2);
        chk(err_count == 2, "R8 count", 64'(err_count), 64'd2);
        chk(err_bits == (m1 | m2), "R8 sticky", 64'(err_bits), 64'(m1 | m2));
        read_fifo(1, -1, '0);

        // R4: replay of loaded samples, corrupted marker word
        for (int a = 0; a < SD; a++) begin
            @(negedge clk);
            smp_we = 1'b1;
            smp_addr = SAW'(a);
            smp_wdata = W'($urandom);
            smp[a] = smp_wdata;
        end
        @(negedge clk) smp_we = 1'b0;
        new_channel();
        m1 = W'($urandom) | (W'(1) << (W - 1));
        run_words(2, 30, 0, m1, -1, '0);
        chk(locked == 1'b1, "R6 lock on marker word", 64'(locked), 64'd1);
        chk(err_count == 1, "R8 marker word compared", 64'(err_count), 64'd1);
        chk(err_bits == m1, "R8 marker word bits", 64'(err_bits), 64'(m1));
        read_fifo(2, 0, m1);

        // R6 R10: arm while a sequence is already running; no marker follows
        cfg_mode = 2'd0;
        @(negedge clk) tx_run = 1'b1;
        repeat (10) @(negedge clk);
        arm_rx();
        chk(err_count == 0, "R10 count cleared", 64'(err_count), 64'd0);
        chk(err_bits == '0, "R10 sticky cleared", 64'(err_bits), 64'd0);
        repeat (TMO + 5) @(negedge clk);
        chk(locked == 1'b0, "R6 no marker no lock", 64'(locked), 64'd0);
        chk(no_lock == 1'b1, "R7 running no marker", 64'(no_lock), 64'd1);
        chk(err_count == 0, "R6 unmarked ignored", 64'(err_count), 64'd0);
        chk(fifo_empty == 1'b1, "R6 nothing captured", 64'(fifo_empty), 64'd1);
        tx_run = 1'b0;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule